// File: doc/BRIEF.md
# Sampling ADC Host Interface Controller

This block sits on the host side of an 8-bit sampling converter whose data comes out in parallel. The converter has three inputs: a convert-start line, an active-low chip select and an active-low read strobe. It has a busy output. The convert-start line does two jobs. Its rising edge wakes the converter. Its falling edge starts a conversion, but only after the converter's internal wake pulse has run out. The level of the line at the moment the conversion completes picks the power mode: low means the converter powers itself down, high means it stays awake.

The user side has three signals. A request is taken while `ready_o` is high, and the mode bit `pdown_i` is sampled with it. A one-cycle `valid_o` comes with the captured byte. A one-cycle `err_o` reports a converter that never went busy.

The controller is an FSM with six states:
- IDLE. Request accepted: go to WAKE.
- WAKE. Convert-start held high for the wake window. Window over: go to START.
- START. Convert-start driven low, waiting for busy. Busy seen: go to CONV. Timeout: go to IDLE.
- CONV. Busy high. Busy low: go to RD_CS.
- RD_CS. Chip select low for one cycle, then go to RD_STROBE.
- RD_STROBE. Read strobe low for the strobe window. Window over: go to IDLE, capturing the byte.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset `convst_o`=0, `cs_n_o`=1, `rd_n_o`=1, `ready_o`=1, `valid_o`=0 and `err_o`=0.
- R2: After a request is accepted, `convst_o` is high for exactly WAKE_CYC = ceil(CLK_MHZ*WAKE_NS/1000) cycles before its falling edge (150 at 100 MHz and 1500 ns).
- R3: `cs_n_o` stays high while `busy_i` is high. It falls on the third clock edge after `busy_i` goes low, because of the two-flop synchroniser plus the state register.
- R4: `cs_n_o` goes low one cycle before `rd_n_o`. `rd_n_o` is low for exactly RD_CYC cycles, and both return high on the same edge.
- R5: `data_o` takes `db_i` (bit 7 is the most significant bit) as sampled in the last strobe cycle. `valid_o` is high for exactly one cycle, on the edge where the strobes are released.
- R6: With `pdown_i`=0 at acceptance (normal mode), `convst_o` is back high before `busy_i` falls and stays high in IDLE afterwards.
- R7: With `pdown_i`=1 at acceptance (power-down mode), `convst_o` stays low through the end of the conversion and in IDLE afterwards.
- R8: If the synchronised busy is not seen high within TIMEOUT_CYC cycles of the falling edge of `convst_o`, `err_o` pulses for one cycle exactly TIMEOUT_CYC cycles after that edge. The block then returns to IDLE with `convst_o` low and no `valid_o`.
- R9: `ready_o` is low from the cycle after acceptance until the read finishes. A request raised while `ready_o` is low is ignored and starts no later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request, taken while ready_o is high |
| pdown_i | input | 1 | Mode for this request: 1 power-down, 0 normal |
| ready_o | output | 1 | High when a request can be accepted |
| valid_o | output | 1 | One-cycle strobe marking data_o as new |
| data_o | output | 8 | Captured conversion result |
| err_o | output | 1 | One-cycle strobe: busy never seen |
| convst_o | output | 1 | Convert-start line to the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| rd_n_o | output | 1 | Active-low read strobe to the converter |
| busy_i | input | 1 | Converter busy, asynchronous |
| db_i | input | 8 | Converter data bus, driven only while both strobes are low |

## Verification
A state that is left too early or too late shows up at once as a wrong pulse width. It appears as the number of high cycles on the convert-start line, the strobe width, or the gap between busy falling and chip select falling, and each of these is counted to the exact cycle. A wrong latched mode shows as the wrong convert-start level at the busy falling edge, within the same conversion. A state that wrongly re-enters WAKE shows as an unexpected convert-start transition or a second valid pulse, within the 200-cycle quiet window after a request that should have been ignored.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_START,
        ST_CONV,
        ST_RD_CS,
        ST_RD_STROBE
    } ctl_state_t;
endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = shift_q[STAGES-1];
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int WAKE_NS     = 1500,
    parameter int TIMEOUT_CYC = 40,
    parameter int RD_CYC      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       pdown_i,
    output logic       ready_o,
    output logic       valid_o,
    output logic [7:0] data_o,
    output logic       err_o,
    output logic       convst_o,
    output logic       cs_n_o,
    output logic       rd_n_o,
    input  logic       busy_i,
    input  logic [7:0] db_i
);
    localparam int WAKE_RAW = (CLK_MHZ * WAKE_NS + 999) / 1000;
    localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int MAX_A    = (WAKE_CYC > TIMEOUT_CYC) ? WAKE_CYC : TIMEOUT_CYC;
    localparam int MAX_LD   = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
    localparam int TW       = $clog2(MAX_LD + 1);

    ctl_state_t state_q, state_d;
    logic       busy_s;
    logic       tmr_load;
    logic [TW-1:0] tmr_val;
    logic       tmr_done;
    logic       mode_pd_q;
    logic       convst_q;
    logic       valid_q;
    logic       err_q;
    logic [7:0] data_q;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) busy_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (busy_i),
        .sync_o  (busy_s)
    );

    adc_phase_timer #(.W(TW)) phase_tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (tmr_done) begin
                    state_d  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TIMEOUT_CYC - 1);
                end
            end
            ST_START: begin
                if (busy_s) begin
                    state_d = ST_CONV;
                end else if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_CONV: begin
                if (!busy_s) begin
                    state_d = ST_RD_CS;
                end
            end
            ST_RD_CS: begin
                state_d  = ST_RD_STROBE;
                tmr_load = 1'b1;
                tmr_val  = TW'(RD_CYC - 1);
            end
            ST_RD_STROBE: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_pd_q <= 1'b0;
            convst_q  <= 1'b0;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (state_q == ST_IDLE && req_i) begin
                mode_pd_q <= pdown_i;
            end
            unique case (state_d)
                ST_WAKE:  convst_q <= 1'b1;
                ST_START: convst_q <= 1'b0;
                ST_CONV, ST_RD_CS, ST_RD_STROBE: convst_q <= !mode_pd_q;
                ST_IDLE: begin
                    if (state_q == ST_START) begin
                        convst_q <= 1'b0;
                        err_q    <= 1'b1;
                    end else if (state_q == ST_RD_STROBE) begin
                        valid_q <= 1'b1;
                        data_q  <= db_i;
                    end
                end
                default: convst_q <= 1'b0;
            endcase
        end
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign cs_n_o   = !((state_q == ST_RD_CS) || (state_q == ST_RD_STROBE));
    assign rd_n_o   = !(state_q == ST_RD_STROBE);
    assign convst_o = convst_q;
    assign valid_o  = valid_q;
    assign err_o    = err_q;
    assign data_o   = data_q;
endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk #(
    parameter int CLK_MHZ = 100,
    parameter int WAKE_NS = 1500
) (
    input logic clk,
    input logic rst_n,
    input logic convst_o,
    input logic cs_n_o,
    input logic rd_n_o,
    input logic busy_i,
    input logic valid_o,
    input logic err_o,
    input logic ready_o
);
    localparam int WAKE_RAW = (CLK_MHZ * WAKE_NS + 999) / 1000;
    localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;

    logic [31:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (convst_o) begin
            if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(convst_o) |-> (hi_cnt >= 32'(WAKE_CYC)));

    assert_no_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> !busy_i);

    assert_rd_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !cs_n_o);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && ready_o));

    assert_not_ready_reading_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> !ready_o);
endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk #(
    .CLK_MHZ (CLK_MHZ),
    .WAKE_NS (WAKE_NS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .convst_o (convst_o),
    .cs_n_o   (cs_n_o),
    .rd_n_o   (rd_n_o),
    .busy_i   (busy_i),
    .valid_o  (valid_o),
    .err_o    (err_o),
    .ready_o  (ready_o)
);

// File: tb/adc_sample_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_sample_ctrl_tb_top;
    localparam int CLK_MHZ     = 100;
    localparam int WAKE_NS     = 1500;
    localparam int TIMEOUT_CYC = 40;
    localparam int RD_CYC      = 3;
    localparam int WAKE_EXP    = 150;
    localparam int CONV_CYC    = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       pdown_i = 1'b0;
    logic       ready_o, valid_o, err_o, convst_o, cs_n_o, rd_n_o;
    logic [7:0] data_o;
    logic       busy_i = 1'b0;
    logic [7:0] model_val = 8'h00;
    logic [7:0] db_i;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    assign db_i = (!cs_n_o && !rd_n_o) ? model_val : 8'hzz;

    adc_sample_ctrl #(
        .CLK_MHZ(CLK_MHZ), .WAKE_NS(WAKE_NS),
        .TIMEOUT_CYC(TIMEOUT_CYC), .RD_CYC(RD_CYC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .pdown_i(pdown_i),
        .ready_o(ready_o), .valid_o(valid_o), .data_o(data_o), .err_o(err_o),
        .convst_o(convst_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
        .busy_i(busy_i), .db_i(db_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(convst_o == 1'b0, "R1 convst", int'(convst_o), 0);
        check(cs_n_o == 1'b1 && rd_n_o == 1'b1, "R1 strobes", int'({cs_n_o, rd_n_o}), 3);
        check(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
        check(valid_o == 1'b0 && err_o == 1'b0, "R1 valid/err", int'({valid_o, err_o}), 0);
    endtask

    task automatic t_convert(input bit pd, input logic [7:0] val, input bit extra_req);
        int hi;
        int gap;
        int rdc;
        bit cs_early;
        logic lvl;
        model_val = val;
        @(negedge clk);
        req_i = 1'b1;
        pdown_i = pd;
        @(negedge clk);
        req_i = 1'b0;
        check(ready_o == 1'b0, "R9 ready low after accept", int'(ready_o), 0);
        hi = 0;
        while (convst_o && hi < 1000) begin
            hi++;
            @(negedge clk);
        end
        check(hi == WAKE_EXP, "R2 wake high cycles", hi, WAKE_EXP);
        repeat (2) @(negedge clk);
        busy_i = 1'b1;
        if (extra_req) req_i = 1'b1;
        cs_early = 1'b0;
        for (int i = 0; i < CONV_CYC; i++) begin
            @(negedge clk);
            req_i = 1'b0;
            if (!cs_n_o) cs_early = 1'b1;
        end
        check(!cs_early, "R3 no chip select while busy", int'(cs_early), 0);
        lvl = convst_o;
        check(lvl == !pd, pd ? "R7 convst at end of conversion" : "R6 convst at end of conversion",
              int'(lvl), int'(!pd));
        busy_i = 1'b0;
        gap = 0;
        while (cs_n_o && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 3, "R3 busy-fall to chip select", gap, 3);
        check(rd_n_o == 1'b1, "R4 chip select precedes read", int'(rd_n_o), 1);
        @(negedge clk);
        rdc = 0;
        while (!rd_n_o && rdc < 100) begin
            if (cs_n_o) check(1'b0, "R4 chip select dropped during read", 1, 0);
            rdc++;
            @(negedge clk);
        end
        check(rdc == RD_CYC, "R4 read strobe width", rdc, RD_CYC);
        check(cs_n_o == 1'b1, "R4 released together", int'(cs_n_o), 1);
        check(valid_o == 1'b1, "R5 valid with release", int'(valid_o), 1);
        check(data_o == val, "R5 captured byte", int'(data_o), int'(val));
        @(negedge clk);
        check(valid_o == 1'b0, "R5 valid one cycle", int'(valid_o), 0);
        check(ready_o == 1'b1, "R9 ready after read", int'(ready_o), 1);
        check(convst_o == !pd, pd ? "R7 idle convst level" : "R6 idle convst level",
              int'(convst_o), int'(!pd));
        if (extra_req) begin
            bit moved = 1'b0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (valid_o || !ready_o || convst_o != !pd) moved = 1'b1;
            end
            check(!moved, "R9 request while busy ignored", int'(moved), 0);
        end
    endtask

    task automatic t_timeout();
        int cnt;
        @(negedge clk);
        req_i = 1'b1;
        pdown_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        cnt = 0;
        while (convst_o && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        cnt = 0;
        while (!err_o && cnt < 1000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == TIMEOUT_CYC, "R8 timeout latency", cnt, TIMEOUT_CYC);
        check(valid_o == 1'b0 && ready_o == 1'b1, "R8 idle, no valid", int'({valid_o, ready_o}), 1);
        check(convst_o == 1'b0, "R8 convst low", int'(convst_o), 0);
        @(negedge clk);
        check(err_o == 1'b0, "R8 error one cycle", int'(err_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_convert(1'b0, 8'hA5, 1'b0);
        t_convert(1'b0, 8'h3C, 1'b0);
        t_convert(1'b1, 8'h81, 1'b0);
        t_convert(1'b1, 8'h5A, 1'b1);
        t_timeout();
        t_convert(1'b0, 8'hFF, 1'b1);
        t_convert(1'b1, 8'h00, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule